// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block sets the timing of current chopping for one full bridge. It is clocked by the oscillator input. When the bridge is asked to drive, it switches the drivers on. It then masks the current-trip comparator for a short programmed window, because switching edges produce false trips. After that window it waits for a genuine trip. A trip ends the on phase and starts an off period of fixed, programmed length. During that period the load current recirculates. At the end of the off period the drivers turn on again and a new masking window begins.

The off period can run entirely in slow decay. It can also run in mixed decay, where fast decay comes first and slow decay covers the rest of the period. The decay indicators go to the gate-drive logic, which picks the recirculation path. The masking length is latched each time an on phase starts. The off length, the fast-decay length and the decay mode are latched at the trip. Configuration changes therefore never disturb a phase that is already running.

Top module: `chop_offtime_timer`

## Requirements
- R1: While reset is asserted and on the first sample after its release, all four outputs are low.
- R2: When `drive_req` is sampled low at a clock edge, the block is idle after that edge (all outputs low), whatever phase it was in.
- R3: Every on phase begins with a masking window in which `drv_on` and `blank_active` are both high. The window lasts 4, 6, 12 or 24 cycles for `blank_code` values 0, 1, 2 and 3. Trips sampled inside the window are ignored.
- R4: After the masking window, `drv_on` stays high with `blank_active` low until `trip` is sampled high. The off period starts in the cycle right after that edge.
- R5: The off period lasts 8*(1+n)-1 cycles, where n is the value of `off_code` (0 to 31).
- R6: When `slow_only` is 0 (mixed decay), `decay_fast` is high for the first 8*(1+m)-1 cycles of the off period, where m is `fast_code` (0 to 15). `decay_slow` is high for the remaining cycles. Fast decay never follows slow decay within one off period.
- R7: In mixed decay, when the fast-decay length is at least the off length, `decay_fast` is high for the whole off period.
- R8: When `slow_only` is 1, `decay_slow` is high for the whole off period and `decay_fast` stays low.
- R9: Trips during the off period are ignored. When the off period ends with `drive_req` high, a new masking window starts at once.
- R10: `blank_code` is captured when a masking window starts. `off_code`, `fast_code` and `slow_only` are captured at the trip. Later changes to them do not affect the running phase.
- R11: Exactly one of `decay_fast` and `decay_slow` is high during the off period. Both are low outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_req | input | 1 | High requests the bridge to drive; low forces idle |
| trip | input | 1 | Current-trip comparator output |
| blank_code | input | 2 | Masking window length select |
| off_code | input | 5 | Off period length code n |
| fast_code | input | 4 | Fast-decay length code m |
| slow_only | input | 1 | 1 selects slow decay, 0 selects mixed decay |
| drv_on | output | 1 | Drivers on (masking window or on phase) |
| blank_active | output | 1 | Comparator masking window active |
| decay_fast | output | 1 | Off period, fast-decay part |
| decay_slow | output | 1 | Off period, slow-decay part |

## Verification
All outputs come straight from registers, so an input held across an edge shows its effect in the very next sample. Examples: a low `drive_req`, a trip in the on phase, or a start request in idle. Inputs are driven on the falling edge and outputs are checked on the following falling edge, so each result is due one sample after its stimulus. A bench-side cycle model predicts the phase after each edge and compares all four outputs on every sample. Directed runs also count the samples of each window and compare those counts with the closed-form lengths: 4/6/12/24 for masking, 8*(1+n)-1 for the off period, and the smaller of the fast and off lengths for fast decay.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_ON    = 2'd2,
    ST_OFF   = 2'd3
  } chop_state_e;

  // Masking window length in oscillator cycles for a 2-bit select.
  function automatic int unsigned mask_cycles(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4;
      2'd1:    return 6;
      2'd2:    return 12;
      default: return 24;
    endcase
  endfunction

  // Timed period for a code: eight cycles per step, one cycle short.
  function automatic int unsigned step_cycles(input int unsigned code);
    return 8 * (code + 1) - 1;
  endfunction

endpackage

// File: rtl/chop_cfg_hold.sv
module chop_cfg_hold #(
  parameter int OFF_W = 5,
  parameter int FD_W  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_mask,
  input  logic             load_off,
  input  logic [1:0]       blank_code,
  input  logic [OFF_W-1:0] off_code,
  input  logic [FD_W-1:0]  fast_code,
  input  logic             slow_only,
  output logic [CNT_W-1:0] mask_len,
  output logic [CNT_W-1:0] off_len,
  output logic [CNT_W-1:0] fast_len,
  output logic             slow_hold
);
  import chop_pkg::*;

  logic [CNT_W-1:0] mask_d, off_d, fast_d;
  logic             slow_d;

  always_comb begin
    mask_d = mask_len;
    off_d  = off_len;
    fast_d = fast_len;
    slow_d = slow_hold;
    if (load_mask) begin
      mask_d = CNT_W'(mask_cycles(blank_code));
    end
    if (load_off) begin
      off_d  = CNT_W'(step_cycles(int'(off_code)));
      fast_d = CNT_W'(step_cycles(int'(fast_code)));
      slow_d = slow_only;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_len  <= '0;
      off_len   <= '0;
      fast_len  <= '0;
      slow_hold <= 1'b0;
    end else begin
      mask_len  <= mask_d;
      off_len   <= off_d;
      fast_len  <= fast_d;
      slow_hold <= slow_d;
    end
  end

endmodule

// File: rtl/chop_counter.sv
module chop_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clr) begin
      count_d = '0;
    end else if (en) begin
      count_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count_d;
    end
  end

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  drive_req,
  input  logic                  trip,
  input  logic                  mask_done,
  input  logic                  off_done,
  output chop_pkg::chop_state_e st_q,
  output chop_pkg::chop_state_e st_d
);
  import chop_pkg::*;

  always_comb begin
    st_d = st_q;
    if (!drive_req) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  st_d = ST_BLANK;
        ST_BLANK: if (mask_done) st_d = ST_ON;
        ST_ON:    if (trip)      st_d = ST_OFF;
        ST_OFF:   if (off_done)  st_d = ST_BLANK;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  AST_REQ_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_req |=> st_q == ST_IDLE) else $error("request low did not idle"); // R2

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLANK && drive_req && !mask_done) |=> st_q == ST_BLANK)
    else $error("masking window left early"); // R3

  AST_TRIP_ENDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ON && drive_req && trip) |=> st_q == ST_OFF)
    else $error("trip did not start off period"); // R4

  AST_OFF_IGNORES_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && drive_req && !off_done) |=> st_q == ST_OFF)
    else $error("off period cut short"); // R9

  AST_OFF_TO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && drive_req && off_done) |=> st_q == ST_BLANK)
    else $error("off period did not return to masking"); // R9

endmodule

// File: rtl/chop_offtime_timer.sv
module chop_offtime_timer #(
  parameter int OFF_W = 5,
  parameter int FD_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_req,
  input  logic             trip,
  input  logic [1:0]       blank_code,
  input  logic [OFF_W-1:0] off_code,
  input  logic [FD_W-1:0]  fast_code,
  input  logic             slow_only,
  output logic             drv_on,
  output logic             blank_active,
  output logic             decay_fast,
  output logic             decay_slow
);
  import chop_pkg::*;

  localparam int CNT_W = ((OFF_W > FD_W) ? OFF_W : FD_W) + 3;

  chop_state_e      st_q, st_d;
  logic [CNT_W-1:0] count, mask_len, off_len, fast_len;
  logic             slow_hold, mask_done, off_done, load_mask, load_off;
  logic             in_off;

  assign load_mask = (st_d == ST_BLANK) && (st_q != ST_BLANK);
  assign load_off  = (st_d == ST_OFF) && (st_q == ST_ON);
  assign mask_done = (count == mask_len - 1'b1);
  assign off_done  = (count == off_len - 1'b1);

  chop_cfg_hold #(.OFF_W(OFF_W), .FD_W(FD_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_mask(load_mask), .load_off(load_off),
    .blank_code(blank_code), .off_code(off_code), .fast_code(fast_code),
    .slow_only(slow_only), .mask_len(mask_len), .off_len(off_len),
    .fast_len(fast_len), .slow_hold(slow_hold)
  );

  chop_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st_d != st_q),
    .en((st_q == ST_BLANK) || (st_q == ST_OFF)), .count(count)
  );

  chop_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .drive_req(drive_req), .trip(trip),
    .mask_done(mask_done), .off_done(off_done), .st_q(st_q), .st_d(st_d)
  );

  assign in_off       = (st_q == ST_OFF);
  assign drv_on       = (st_q == ST_BLANK) || (st_q == ST_ON);
  assign blank_active = (st_q == ST_BLANK);
  assign decay_fast   = in_off && !slow_hold && (count < fast_len);
  assign decay_slow   = in_off && !decay_fast;

  AST_DECAY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    in_off |-> $onehot({decay_fast, decay_slow}))
    else $error("decay indicators not one-hot"); // R11

  AST_DECAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_off |-> !(decay_fast || decay_slow))
    else $error("decay indicator outside off period"); // R11

  AST_NO_FAST_AFTER_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (decay_slow && drive_req && !off_done) |=> !decay_fast)
    else $error("fast decay after slow decay"); // R6

  AST_SLOW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_off && slow_hold) |-> !decay_fast)
    else $error("fast decay in slow mode"); // R8

endmodule

// File: tb/sim_chop_offtime_timer.sv
module sim_chop_offtime_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drive_req = 1'b0, trip = 1'b0, slow_only = 1'b0;
  logic [1:0] blank_code = '0;
  logic [4:0] off_code = '0;
  logic [3:0] fast_code = '0;
  logic       drv_on, blank_active, decay_fast, decay_slow;

  int total = 0, bad = 0, cycles = 0;

  // cycle model: 0 idle, 1 mask, 2 on, 3 off
  int ms = 0, mcnt = 0, mblen = 0, molen = 0, mflen = 0;
  bit mslow = 0;

  always #4 clk = ~clk;

  chop_offtime_timer u0 (
    .clk(clk), .rst_n(rst_n), .drive_req(drive_req), .trip(trip),
    .blank_code(blank_code), .off_code(off_code), .fast_code(fast_code),
    .slow_only(slow_only), .drv_on(drv_on), .blank_active(blank_active),
    .decay_fast(decay_fast), .decay_slow(decay_slow)
  );

  function automatic int f_mask(input int c);
    case (c)
      0: return 4;
      1: return 6;
      2: return 12;
      default: return 24;
    endcase
  endfunction

  function automatic int f_per(input int c);
    return 8 * (c + 1) - 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_adv();
    if (!drive_req) begin
      ms = 0; mcnt = 0;
    end else begin
      case (ms)
        0: begin ms = 1; mcnt = 0; mblen = f_mask(int'(blank_code)); end
        1: if (mcnt == mblen - 1) begin ms = 2; mcnt = 0; end else mcnt++;
        2: if (trip) begin
             ms = 3; mcnt = 0; molen = f_per(int'(off_code));
             mflen = f_per(int'(fast_code)); mslow = slow_only;
           end
        default: if (mcnt == molen - 1) begin
             ms = 1; mcnt = 0; mblen = f_mask(int'(blank_code));
           end else mcnt++;
      endcase
    end
  endtask

  task automatic model_check();
    bit ef, eo;
    int act, exp;
    string tag;
    eo = (ms == 1) || (ms == 2);
    ef = (ms == 3) && !mslow && (mcnt < mflen);
    exp = {eo, ms == 1, ef, (ms == 3) && !ef};
    act = {drv_on, blank_active, decay_fast, decay_slow};
    case (ms)
      0: tag = "R2";
      1: tag = "R3";
      2: tag = "R4";
      default: tag = mslow ? "R8" : (mflen >= molen ? "R7" : "R6");
    endcase
    check(act == exp, tag, act, exp);
  endtask

  // drive at falling edge, check at next falling edge
  task automatic step(input bit req, input bit tr);
    drive_req = req; trip = tr;
    model_adv();
    @(negedge clk);
    model_check();
  endtask

  task automatic directed(input int bc, input int oc, input int fc, input bit so,
                          input bit scramble);
    int nb, nf, ns, expf;
    blank_code = 2'(bc); off_code = 5'(oc); fast_code = 4'(fc); slow_only = so;
    step(0, 0);
    nb = 0;
    step(1, 1);  // trips inside the masking window are ignored
    while (blank_active && nb < 100) begin nb++; step(1, 1); end
    check(nb == f_mask(bc), "R3", nb, f_mask(bc));
    check(drv_on && !blank_active, "R4", drv_on, 1);
    step(1, 0);
    step(1, 1);
    nf = 0; ns = 0;
    while ((decay_fast || decay_slow) && (nf + ns) < 600) begin
      if (decay_fast) nf++; else ns++;
      if (scramble) begin
        blank_code = 2'(bc); off_code = ~5'(oc); fast_code = ~4'(fc); slow_only = ~so;
      end
      step(1, 1);
    end
    check(nf + ns == f_per(oc), scramble ? "R10" : "R5", nf + ns, f_per(oc));
    expf = so ? 0 : (f_per(fc) < f_per(oc) ? f_per(fc) : f_per(oc));
    check(nf == expf, so ? "R8" : (f_per(fc) >= f_per(oc) ? "R7" : "R6"), nf, expf);
    check(blank_active && drv_on, "R9", blank_active, 1);
    step(0, 0);
    check(!drv_on && !blank_active, "R2", drv_on, 0);
  endtask

  initial begin
    void'($urandom(32'h1c3a5));
    repeat (3) @(negedge clk);
    check({drv_on, blank_active, decay_fast, decay_slow} == 0, "R1",
          {drv_on, blank_active, decay_fast, decay_slow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({drv_on, blank_active, decay_fast, decay_slow} == 0, "R1",
          {drv_on, blank_active, decay_fast, decay_slow}, 0);

    directed(0, 0, 0, 0, 0);
    directed(1, 3, 0, 0, 0);
    directed(2, 2, 15, 0, 0);
    directed(3, 31, 15, 0, 0);
    directed(3, 31, 7, 0, 0);
    directed(0, 5, 1, 1, 0);
    directed(1, 4, 2, 0, 1);
    directed(2, 1, 6, 1, 1);

    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(15) == 0) begin
        blank_code = 2'($urandom); off_code = 5'($urandom_range(6));
        fast_code = 4'($urandom_range(7)); slow_only = 1'($urandom_range(3) == 0);
      end
      step($urandom_range(63) != 0, $urandom_range(7) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

endmodule